// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset this block copies the whole image of a serial EEPROM into a small internal configuration register file, using the Microwire three-wire protocol. For each word it issues a read frame and shifts the returned word in. It writes the word to the register file and adds it to a running 16-bit checksum. It learns from a strap input whether a device is fitted at all. When no device is fitted it leaves the register file at its defaults and never touches the serial pins.

A shift-busy output frames the load. It goes high when loading starts and stays high for the whole transfer, so external shift registers can use it as a capture enable on the serial stream. It returns low only if the image checksum is good. After a bad image it stays high, so as an active-low enable it marks a trusted configuration. A failed load also clears the register file back to its defaults and raises a sticky error flag. Either outcome ends with a one-cycle done pulse. Host logic can force shift-busy to any level with a write strobe and a value bit.

Top module: `eeprom_loader`

## Requirements
- R1: While rst_ni is low, mw_cs_o, mw_sk_o, mw_di_o, shift_busy_o, present_o, done_o and error_o are all 0, and every configuration word reads 0.
- R2: strap_det_i is sampled on the first rising clock edge after reset is released, and present_o holds that value. When it is 0, mw_cs_o never rises, done_o never pulses, shift_busy_o stays 0 and every configuration word stays 0.
- R3: Each frame raises mw_cs_o with mw_sk_o low. On mw_di_o it then presents, one bit per SK rising edge, the bits 1, 1, 0 followed by the 6-bit word address MSB first. The bit returned on mw_do_i during the last address bit is discarded. The next 16 bits are captured MSB first, each sampled just before the SK falling edge. mw_sk_o only rises while mw_cs_o is high.
- R4: Words are read at addresses 0 to NUM_WORDS-1 in ascending order, one frame each. Each word is stored at its own index and is readable combinationally on cfg_rdata_o at cfg_raddr_i.
- R5: Inside a frame, SK rising edges are exactly 2*SK_HALF clock cycles apart. mw_cs_o stays low for at least 2*SK_HALF cycles between frames, and mw_sk_o is 0 whenever mw_cs_o is 0.
- R6: When a device is present, shift_busy_o is 1 from the cycle after the strap sample and stays 1 whenever mw_cs_o is high.
- R7: If the modulo-2^16 sum of all words equals 16'hFFFF, then shift_busy_o is 0 and error_o is 0 in the cycle done_o is high, and the stored words are kept.
- R8: If the sum differs from 16'hFFFF, then in the cycle done_o is high, shift_busy_o stays 1, error_o is 1 and every configuration word reads 0. error_o then stays 1 until reset.
- R9: done_o is high for exactly one clock cycle at the end of each load, whatever the checksum result.
- R10: When host_sb_we_i is high at a clock edge, shift_busy_o takes the value of host_sb_val_i after that edge, overriding the loader.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_det_i | input | 1 | Device-fitted strap, 1 = EEPROM present |
| mw_cs_o | output | 1 | Microwire chip select |
| mw_sk_o | output | 1 | Microwire serial clock |
| mw_di_o | output | 1 | Serial data to the EEPROM |
| mw_do_i | input | 1 | Serial data from the EEPROM |
| host_sb_we_i | input | 1 | Host write strobe for shift-busy |
| host_sb_val_i | input | 1 | Value written to shift-busy |
| cfg_raddr_i | input | $clog2(NUM_WORDS) | Configuration word read index |
| cfg_rdata_o | output | DATA_W | Configuration word read data |
| shift_busy_o | output | 1 | Load in progress / checksum-not-yet-good flag |
| present_o | output | 1 | Latched strap value |
| done_o | output | 1 | One-cycle end-of-load pulse |
| error_o | output | 1 | Sticky checksum failure flag |

## Verification
The bound checker watches several properties on every cycle: the serial clock stays quiet outside chip select, the done pulse lasts one cycle, the error flag is sticky and rises only with done, and the bus stays silent after an absent strap. Other behaviours need the bench's scenarios and its Microwire EEPROM model. These are the exact bit order of the command, the address sequence, the stored word values, the SK period and the chip-select gap. The same holds for the difference between a good and a bad image: register contents, shift-busy level and error flag at the end. The host override is also checked only in the scenarios.

// File: rtl/eel_pkg.sv
package eel_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_GAP, ENG_SHIFT} eng_state_t;
  typedef enum logic [2:0] {CTL_STRAP, CTL_ISSUE, CTL_WAIT, CTL_CHECK, CTL_HALT} ctl_state_t;
  localparam logic [2:0] MW_READ_CMD = 3'b110; // start bit, then read opcode
endpackage

// File: rtl/eel_tick_gen.sv
module eel_tick_gen #(
  parameter int SK_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == CW'(SK_HALF - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/eel_mw_engine.sv
module eel_mw_engine #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mw_do_i,
  output logic              mw_cs_o,
  output logic              mw_sk_o,
  output logic              mw_di_o,
  output logic              word_vld_o,
  output logic [DATA_W-1:0] word_o
);
  import eel_pkg::*;
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int BW      = $clog2(FRAME_W);

  eng_state_t        st_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [BW-1:0]     bit_q;
  logic              gap_q, cs_q, sk_q, vld_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENG_IDLE;
      cmd_q  <= '0;
      bit_q  <= '0;
      gap_q  <= 1'b0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        ENG_IDLE: if (start_i) begin
          cmd_q <= {MW_READ_CMD, addr_i};
          gap_q <= 1'b0;
          st_q  <= ENG_GAP;
        end
        // hold CS low for two ticks (one SK period) before the frame
        ENG_GAP: if (tick_i) begin
          gap_q <= 1'b1;
          if (gap_q) begin
            cs_q  <= 1'b1;
            bit_q <= '0;
            st_q  <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: if (tick_i) begin
          if (!sk_q) begin
            sk_q <= 1'b1;
          end else begin
            sk_q <= 1'b0;
            if (bit_q >= BW'(CMD_W))
              data_q <= {data_q[DATA_W-2:0], mw_do_i};
            if (bit_q == BW'(FRAME_W - 1)) begin
              cs_q  <= 1'b0;
              vld_q <= 1'b1;
              st_q  <= ENG_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1;
              cmd_q <= cmd_q << 1;
            end
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign mw_cs_o    = cs_q;
  assign mw_sk_o    = sk_q;
  assign mw_di_o    = cs_q & cmd_q[CMD_W-1];
  assign word_vld_o = vld_q;
  assign word_o     = data_q;
endmodule

// File: rtl/eel_cfg_regs.sv
module eel_cfg_regs #(
  parameter int              NUM_WORDS = 16,
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         we_i,
  input  logic [$clog2(NUM_WORDS)-1:0] waddr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [$clog2(NUM_WORDS)-1:0] raddr_i,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int IW = $clog2(NUM_WORDS);
  logic [DATA_W-1:0] mem_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= RST_VAL;
      else if (clr_i)                            mem_q[g] <= RST_VAL;
      else if (we_i && (waddr_i == IW'(g)))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader #(
  parameter int SK_HALF   = 4,
  parameter int NUM_WORDS = 16,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         strap_det_i,
  output logic                         mw_cs_o,
  output logic                         mw_sk_o,
  output logic                         mw_di_o,
  input  logic                         mw_do_i,
  input  logic                         host_sb_we_i,
  input  logic                         host_sb_val_i,
  input  logic [$clog2(NUM_WORDS)-1:0] cfg_raddr_i,
  output logic [DATA_W-1:0]            cfg_rdata_o,
  output logic                         shift_busy_o,
  output logic                         present_o,
  output logic                         done_o,
  output logic                         error_o
);
  import eel_pkg::*;
  localparam int                IW        = $clog2(NUM_WORDS);
  localparam logic [DATA_W-1:0] SUM_GOOD  = '1;
  localparam logic [IW-1:0]     LAST_IDX  = IW'(NUM_WORDS - 1);

  ctl_state_t        st_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sum_q;
  logic              present_q, sb_q, done_q, err_q;
  logic              tick, start, word_vld, wr_en, clr;
  logic [DATA_W-1:0] word;

  eel_tick_gen #(.SK_HALF(SK_HALF)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  eel_mw_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .start_i    (start),
    .addr_i     (ADDR_W'(idx_q)),
    .mw_do_i    (mw_do_i),
    .mw_cs_o    (mw_cs_o),
    .mw_sk_o    (mw_sk_o),
    .mw_di_o    (mw_di_o),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  assign start = (st_q == CTL_ISSUE);
  assign wr_en = (st_q == CTL_WAIT) && word_vld;
  assign clr   = (st_q == CTL_CHECK) && (sum_q != SUM_GOOD);

  eel_cfg_regs #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .we_i    (wr_en),
    .waddr_i (idx_q),
    .wdata_i (word),
    .raddr_i (cfg_raddr_i),
    .rdata_o (cfg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= CTL_STRAP;
      idx_q     <= '0;
      sum_q     <= '0;
      present_q <= 1'b0;
      sb_q      <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        CTL_STRAP: begin
          present_q <= strap_det_i;
          if (strap_det_i) begin
            sb_q <= 1'b1;
            st_q <= CTL_ISSUE;
          end else begin
            st_q <= CTL_HALT;
          end
        end
        CTL_ISSUE: st_q <= CTL_WAIT;
        CTL_WAIT: if (word_vld) begin
          sum_q <= sum_q + word;
          if (idx_q == LAST_IDX) begin
            st_q <= CTL_CHECK;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= CTL_ISSUE;
          end
        end
        CTL_CHECK: begin
          done_q <= 1'b1;
          if (sum_q == SUM_GOOD) sb_q  <= 1'b0;
          else                   err_q <= 1'b1;
          st_q <= CTL_HALT;
        end
        CTL_HALT: st_q <= CTL_HALT;
        default:  st_q <= CTL_HALT;
      endcase
      if (host_sb_we_i) sb_q <= host_sb_val_i; // host write wins
    end
  end

  assign shift_busy_o = sb_q;
  assign present_o    = present_q;
  assign done_o       = done_q;
  assign error_o      = err_q;
endmodule

// File: rtl/eel_loader_chk.sv
module eel_loader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mw_cs_o,
  input logic mw_sk_o,
  input logic present_o,
  input logic done_o,
  input logic error_o
);
  p_sk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mw_cs_o |-> !mw_sk_o);

  p_sk_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mw_sk_o) |-> mw_cs_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);

  p_err_at_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o);

  p_absent_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_o |-> (!mw_cs_o && !done_o));
endmodule

bind eeprom_loader eel_loader_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mw_cs_o   (mw_cs_o),
  .mw_sk_o   (mw_sk_o),
  .present_o (present_o),
  .done_o    (done_o),
  .error_o   (error_o)
);

// File: tb/eeprom_loader_test.sv
module eeprom_loader_test;
  localparam int SK_HALF = 4;
  localparam int NW      = 16;
  localparam int DW      = 16;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, ee_do = 1'b0;
  logic hwe = 1'b0, hval = 1'b0;
  logic [3:0] raddr = '0;
  logic cs, sk, di, sb, pres, done, err;
  logic [DW-1:0] rdata;

  always #5 clk = ~clk;

  eeprom_loader #(.SK_HALF(SK_HALF), .NUM_WORDS(NW), .ADDR_W(6), .DATA_W(DW)) uut (
    .clk_i (clk), .rst_ni (rst_n), .strap_det_i (strap),
    .mw_cs_o (cs), .mw_sk_o (sk), .mw_di_o (di), .mw_do_i (ee_do),
    .host_sb_we_i (hwe), .host_sb_val_i (hval),
    .cfg_raddr_i (raddr), .cfg_rdata_o (rdata),
    .shift_busy_o (sb), .present_o (pres), .done_o (done), .error_o (err)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [NW];

  // EEPROM model and bus monitors
  int cyc = 0, rx_cnt = 0, nlog = 0, frame_err = 0;
  int per_err = 0, gap_err = 0, busy_err = 0, cs_rises = 0, done_cnt = 0;
  int t_sk = 0, t_csf = 0;
  bit sk_seen = 0, csf_seen = 0;
  logic [8:0]  rx_sr = '0;
  logic [15:0] cur = '0;
  logic [5:0]  addr_log [64];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && cs && !sb) busy_err = busy_err + 1;
    if (done) done_cnt = done_cnt + 1;
  end

  always @(negedge cs) begin
    rx_cnt = 0; sk_seen = 0; t_csf = cyc; csf_seen = 1;
  end

  always @(posedge cs) begin
    cs_rises = cs_rises + 1;
    if (csf_seen && (cyc - t_csf) < 2*SK_HALF) gap_err = gap_err + 1;
  end

  always @(posedge sk) if (cs) begin
    if (sk_seen && (cyc - t_sk) != 2*SK_HALF) per_err = per_err + 1;
    sk_seen = 1; t_sk = cyc;
    if (rx_cnt < 9) begin
      rx_sr  = {rx_sr[7:0], di};
      rx_cnt = rx_cnt + 1;
      if (rx_cnt == 9) begin
        if (rx_sr[8:6] != 3'b110 || rx_sr[5:4] != 2'b00) frame_err = frame_err + 1;
        if (nlog < 64) addr_log[nlog] = rx_sr[5:0];
        nlog  = nlog + 1;
        cur   = mem[rx_sr[3:0]];
        ee_do = 1'b0;
      end
    end else begin
      ee_do = cur[15];
      cur   = {cur[14:0], 1'b0};
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_image(input bit good);
    logic [15:0] s = '0;
    for (int i = 0; i < NW - 1; i++) begin
      mem[i] = 16'(i * 16'h1111 + 16'h0203);
      s = s + mem[i];
    end
    mem[NW-1] = 16'hFFFF - s + (good ? 16'h0 : 16'h1);
  endtask

  task automatic do_reset(input logic strap_v, input bit check_idle);
    rst_n = 1'b0; strap = strap_v; hwe = 1'b0; hval = 1'b0;
    nlog = 0; frame_err = 0; per_err = 0; gap_err = 0; busy_err = 0;
    cs_rises = 0; done_cnt = 0; csf_seen = 0;
    repeat (3) @(negedge clk);
    if (check_idle) begin
      chk("R1", "reset outputs", {cs, sk, di, sb, pres, done, err}, 7'b0);
      raddr = 4'd5; #1;
      chk("R1", "reset reg5", rdata, 16'h0);
    end
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic check_regs(input string req, input bit expect_image);
    int bad = 0;
    for (int i = 0; i < NW; i++) begin
      raddr = 4'(i); #1;
      if (rdata !== (expect_image ? mem[i] : 16'h0)) bad++;
    end
    chk(req, "register file mismatches", bad, 0);
  endtask

  task automatic test_absent();
    do_reset(1'b0, 1'b1);
    repeat (3000) @(negedge clk);
    chk("R2", "present_o", pres, 0);
    chk("R2", "cs rises", cs_rises, 0);
    chk("R2", "done pulses", done_cnt, 0);
    chk("R2", "shift_busy", sb, 0);
    check_regs("R2", 1'b0);
  endtask

  task automatic test_good();
    fill_image(1'b1);
    do_reset(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6", "busy at start", sb, 1);
    chk("R2", "present_o", pres, 1);
    wait_done();
    chk("R9", "done seen", done, 1);
    chk("R7", "busy at done", sb, 0);
    chk("R7", "error at done", err, 0);
    @(negedge clk);
    chk("R9", "done width", done_cnt, 1);
    repeat (20) @(negedge clk);
    chk("R6", "busy low during frame", busy_err, 0);
    chk("R3", "frame format errors", frame_err, 0);
    chk("R4", "frame count", nlog, NW);
    for (int k = 0; k < NW; k++) chk("R4", "address order", addr_log[k], k);
    chk("R5", "sk period errors", per_err, 0);
    chk("R5", "cs gap errors", gap_err, 0);
    check_regs("R7", 1'b1);
    check_regs("R4", 1'b1);
  endtask

  task automatic test_host();
    hwe = 1'b1; hval = 1'b1; @(negedge clk); hwe = 1'b0;
    chk("R10", "host set busy", sb, 1);
    repeat (5) @(negedge clk);
    chk("R10", "host value held", sb, 1);
    hwe = 1'b1; hval = 1'b0; @(negedge clk); hwe = 1'b0;
    chk("R10", "host clear busy", sb, 0);
  endtask

  task automatic test_bad();
    fill_image(1'b0);
    do_reset(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6", "busy at start", sb, 1);
    wait_done();
    chk("R9", "done seen", done, 1);
    chk("R8", "busy held", sb, 1);
    chk("R8", "error set", err, 1);
    check_regs("R8", 1'b0);
    repeat (100) @(negedge clk);
    chk("R9", "done width", done_cnt, 1);
    chk("R8", "error sticky", err, 1);
    chk("R8", "busy still high", sb, 1);
    chk("R3", "frame format errors", frame_err, 0);
    hwe = 1'b1; hval = 1'b0; @(negedge clk); hwe = 1'b0;
    chk("R10", "host clears after failure", sb, 0);
  endtask

  initial begin
    test_absent();
    test_good();
    test_host();
    test_bad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule